// File: doc/BRIEF.md
# Locked Sequence Arbiter for Two or More Upstream Ports

This block decides which upstream port may use a shared downstream request path, and it enforces the rules of locked (atomic) access sequences. Each port has separate read and write request lines. Each request carries a lock flag and a cacheable flag. The block answers every request with a one-cycle accept strobe. When a locked request arrives, the block picks one port to own the sequence, with the lowest index winning. It then shuts out every other port and waits until all internal buffers report empty. Only after that does it let the owner's locked transfers through, one outstanding at a time.

For each accepted transfer the block decides two things. First, it decides whether the transfer needs the downstream path at all: a cacheable read that hits in the cache is served locally. Second, it decides whether the downstream request carries the lock attribute, which only non-cacheable locked transfers do. Cache lookups, data movement and the buffers themselves live outside the block. Only their hit and empty status enter here.

Three error strobes report misuse by the requester:
- a second locked transfer offered while one is still outstanding;
- a change of cacheability inside a sequence;
- a locked read and a locked write that open a sequence together on one port.

Top module: `lock_seq_arbiter`

## Requirements
- R1: When locked requests are present on several ports in an idle cycle, the lowest-numbered port becomes the sequence owner. No request is accepted in that cycle.
- R2: From the cycle after a sequence starts until the block is idle again, no port other than the owner receives an accept. This covers locked and non-locked requests, cacheable or not.
- R3: A locked transfer is accepted at the earliest in the cycle after the first cycle in which every bit of `buf_empty` is 1. Nothing is accepted while the block waits for the buffers.
- R4: An accepted non-cacheable locked transfer is forwarded with `dn_lock`=1, `dn_write` giving the channel (1 = write) and `dn_port` giving the binary port index.
- R5: A cacheable locked read is accepted without a downstream request when `lookup_hit`=1. On a miss it is forwarded as a read with `dn_lock`=0.
- R6: A cacheable locked write is forwarded as a write with `dn_lock`=0.
- R7: After a locked transfer is accepted, no further locked transfer of the owner is accepted until the owner's `txn_done` pulses. A locked request offered in that time is not accepted, and `err_outstanding` is 1 in the following cycle.
- R8: A locked transfer accepted with a cacheable flag different from the one that opened the sequence raises `err_mix` for one cycle, in the following cycle. The transfer is still forwarded.
- R9: If a sequence opens with a locked read and a locked write together on the owner port, `err_dual` is 1 in the following cycle. The read is accepted first.
- R10: A non-locked request from the owner, with nothing outstanding, ends the sequence. That request is not accepted. The next cycle accepts nothing, and the cycle after it arbitrates normally again.
- R11: Outside a sequence, with no locked request present, the lowest-numbered requesting port is served, its read before its write, at most one accept per cycle. A request that needs the downstream path is accepted only in a cycle with `dn_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_req | input | NUM_PORTS | Read request, one bit per port |
| rd_lock | input | NUM_PORTS | Lock flag of each port's read |
| rd_cache | input | NUM_PORTS | Cacheable flag of each port's read |
| wr_req | input | NUM_PORTS | Write request, one bit per port |
| wr_lock | input | NUM_PORTS | Lock flag of each port's write |
| wr_cache | input | NUM_PORTS | Cacheable flag of each port's write |
| rd_ack | output | NUM_PORTS | Read accepted at this clock edge |
| wr_ack | output | NUM_PORTS | Write accepted at this clock edge |
| txn_done | input | NUM_PORTS | Completion pulse of a port's outstanding transfer |
| lookup_hit | input | 1 | Cache lookup result for the currently selected read |
| buf_empty | input | NUM_BUFS | Empty status of each internal buffer, store buffer included |
| dn_valid | output | 1 | Downstream request present |
| dn_ready | input | 1 | Downstream path can take the request |
| dn_write | output | 1 | Downstream request is a write |
| dn_lock | output | 1 | Downstream request carries the lock attribute |
| dn_port | output | PORT_W | Index of the port the request comes from |
| err_outstanding | output | 1 | Second locked transfer offered while one is outstanding |
| err_mix | output | 1 | Cacheability changed inside a sequence |
| err_dual | output | 1 | Sequence opened by a locked read and write together |

## Verification
The bench builds the block with three ports and two buffer-empty inputs. The third port is never a lock contender. It keeps a non-locked write pending through two complete sequences, so shut-out of a bystander is shown alongside the loser of the priority contest. Two empty bits let one buffer hold the sequence in its wait state while the other already reports empty. A scoreboard queues every downstream request the bench predicts and matches each one, including its lock attribute, against the handshakes it observes.

// File: rtl/lock_seq_pkg.sv
package lock_seq_pkg;

  typedef enum logic [1:0] {
    LS_IDLE    = 2'd0,
    LS_DRAIN   = 2'd1,
    LS_LOCKED  = 2'd2,
    LS_RELEASE = 2'd3
  } lock_state_e;

endpackage

// File: rtl/lock_seq_pick.sv
// Fixed-priority picker: lowest set index wins.
module lock_seq_pick #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/lock_seq_issue.sv
// Decides whether a selected transfer uses the downstream path and
// whether it carries the lock attribute there.
module lock_seq_issue (
  input  logic sel_write,
  input  logic sel_lock,
  input  logic sel_cache,
  input  logic lookup_hit,
  input  logic in_sequence,
  output logic need_dn,
  output logic lock_attr
);

  logic local_hit;

  always_comb begin
    local_hit = sel_cache && !sel_write && lookup_hit;
    need_dn   = !local_hit;
    lock_attr = in_sequence && sel_lock && !sel_cache;
  end

endmodule

// File: rtl/lock_seq_ctrl.sv
// Sequence state, owner, opening cacheability and outstanding tracking.
module lock_seq_ctrl
  import lock_seq_pkg::*;
#(
  parameter int PORT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PORT_W-1:0] start_port,
  input  logic              start_cache,
  input  logic              all_empty,
  input  logic              end_seq,
  input  logic              lock_acc,
  input  logic              owner_done,
  output lock_state_e       state,
  output logic [PORT_W-1:0] owner,
  output logic              seq_cache,
  output logic              busy
);

  lock_state_e       state_d;
  logic              load_owner;
  logic              busy_en;
  logic              busy_d;

  always_comb begin
    state_d    = state;
    load_owner = 1'b0;
    unique case (state)
      LS_IDLE: begin
        if (start) begin
          state_d    = LS_DRAIN;
          load_owner = 1'b1;
        end
      end
      LS_DRAIN:   if (all_empty) state_d = LS_LOCKED;
      LS_LOCKED:  if (end_seq)   state_d = LS_RELEASE;
      LS_RELEASE: state_d = LS_IDLE;
      default:    state_d = LS_IDLE;
    endcase
  end

  always_comb begin
    busy_en = lock_acc || owner_done;
    busy_d  = lock_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LS_IDLE;
    end else begin
      state <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner     <= '0;
      seq_cache <= 1'b0;
    end else if (load_owner) begin
      owner     <= start_port;
      seq_cache <= start_cache;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (busy_en) begin
      busy <= busy_d;
    end
  end

endmodule

// File: rtl/lock_seq_arbiter.sv
module lock_seq_arbiter
  import lock_seq_pkg::*;
#(
  parameter int  NUM_PORTS = 2,
  parameter int  NUM_BUFS  = 3,
  localparam int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] rd_req,
  input  logic [NUM_PORTS-1:0] rd_lock,
  input  logic [NUM_PORTS-1:0] rd_cache,
  input  logic [NUM_PORTS-1:0] wr_req,
  input  logic [NUM_PORTS-1:0] wr_lock,
  input  logic [NUM_PORTS-1:0] wr_cache,
  output logic [NUM_PORTS-1:0] rd_ack,
  output logic [NUM_PORTS-1:0] wr_ack,
  input  logic [NUM_PORTS-1:0] txn_done,
  input  logic                 lookup_hit,
  input  logic [NUM_BUFS-1:0]  buf_empty,
  output logic                 dn_valid,
  input  logic                 dn_ready,
  output logic                 dn_write,
  output logic                 dn_lock,
  output logic [PORT_W-1:0]    dn_port,
  output logic                 err_outstanding,
  output logic                 err_mix,
  output logic                 err_dual
);

  lock_state_e         seq_state;
  logic [PORT_W-1:0]   owner_q;
  logic                seq_cache_q;
  logic                seq_busy;

  logic [NUM_PORTS-1:0] port_lockreq;
  logic [NUM_PORTS-1:0] port_any;
  logic                 lk_found;
  logic [PORT_W-1:0]    lk_idx;
  logic                 any_found;
  logic [PORT_W-1:0]    any_idx;

  logic                 sel_valid;
  logic                 sel_rd;
  logic [PORT_W-1:0]    sel_port;
  logic                 sel_write;
  logic                 sel_lock;
  logic                 sel_cache;

  logic                 start;
  logic                 start_cache;
  logic                 can_go;
  logic                 end_seq;
  logic                 outst_c;
  logic                 mix_c;
  logic                 dual_c;
  logic                 need_dn;
  logic                 lock_attr;
  logic                 acc;
  logic                 lock_acc;
  logic                 in_sequence;

  always_comb begin
    port_lockreq = (rd_req & rd_lock) | (wr_req & wr_lock);
    port_any     = rd_req | wr_req;
  end

  lock_seq_pick #(.N(NUM_PORTS), .IW(PORT_W)) u_pick_lock (
    .req   (port_lockreq),
    .found (lk_found),
    .idx   (lk_idx)
  );

  lock_seq_pick #(.N(NUM_PORTS), .IW(PORT_W)) u_pick_any (
    .req   (port_any),
    .found (any_found),
    .idx   (any_idx)
  );

  // Which port and channel is looked at this cycle.
  always_comb begin
    sel_valid = 1'b0;
    sel_port  = '0;
    sel_rd    = 1'b0;
    unique case (seq_state)
      LS_IDLE: begin
        if (!lk_found && any_found) begin
          sel_valid = 1'b1;
          sel_port  = any_idx;
          sel_rd    = rd_req[any_idx];
        end
      end
      LS_LOCKED: begin
        sel_port  = owner_q;
        sel_valid = port_any[owner_q];
        sel_rd    = rd_req[owner_q];
      end
      default: begin
        sel_valid = 1'b0;
      end
    endcase
  end

  always_comb begin
    sel_write = !sel_rd;
    sel_lock  = sel_rd ? rd_lock[sel_port]  : wr_lock[sel_port];
    sel_cache = sel_rd ? rd_cache[sel_port] : wr_cache[sel_port];
  end

  // Sequence opening, acceptance gating and error conditions.
  always_comb begin
    start       = 1'b0;
    start_cache = 1'b0;
    dual_c      = 1'b0;
    can_go      = 1'b0;
    end_seq     = 1'b0;
    outst_c     = 1'b0;
    mix_c       = 1'b0;
    unique case (seq_state)
      LS_IDLE: begin
        if (lk_found) begin
          start       = 1'b1;
          start_cache = (rd_req[lk_idx] && rd_lock[lk_idx]) ? rd_cache[lk_idx]
                                                            : wr_cache[lk_idx];
          dual_c      = rd_req[lk_idx] && rd_lock[lk_idx] &&
                        wr_req[lk_idx] && wr_lock[lk_idx];
        end else begin
          can_go = any_found;
        end
      end
      LS_LOCKED: begin
        if (sel_valid) begin
          if (sel_lock) begin
            if (seq_busy) begin
              outst_c = 1'b1;
            end else begin
              can_go = 1'b1;
              mix_c  = (sel_cache != seq_cache_q);
            end
          end else if (!seq_busy) begin
            end_seq = 1'b1;
          end
        end
      end
      default: begin
        can_go = 1'b0;
      end
    endcase
  end

  assign in_sequence = (seq_state == LS_LOCKED);

  lock_seq_issue u_issue (
    .sel_write   (sel_write),
    .sel_lock    (sel_lock),
    .sel_cache   (sel_cache),
    .lookup_hit  (lookup_hit),
    .in_sequence (in_sequence),
    .need_dn     (need_dn),
    .lock_attr   (lock_attr)
  );

  always_comb begin
    acc      = sel_valid && can_go && (!need_dn || dn_ready);
    dn_valid = sel_valid && can_go && need_dn;
    dn_write = sel_write;
    dn_lock  = dn_valid && lock_attr;
    dn_port  = sel_port;
    lock_acc = acc && in_sequence && sel_lock;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ack
    assign rd_ack[p] = acc && sel_rd    && (sel_port == PORT_W'(p));
    assign wr_ack[p] = acc && sel_write && (sel_port == PORT_W'(p));
  end

  lock_seq_ctrl #(.PORT_W(PORT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_port  (lk_idx),
    .start_cache (start_cache),
    .all_empty   (&buf_empty),
    .end_seq     (end_seq),
    .lock_acc    (lock_acc),
    .owner_done  (txn_done[owner_q]),
    .state       (seq_state),
    .owner       (owner_q),
    .seq_cache   (seq_cache_q),
    .busy        (seq_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_outstanding <= 1'b0;
      err_mix         <= 1'b0;
      err_dual        <= 1'b0;
    end else begin
      err_outstanding <= outst_c;
      err_mix         <= mix_c;
      err_dual        <= dual_c;
    end
  end

endmodule

// File: rtl/lock_seq_checker.sv
module lock_seq_checker
  import lock_seq_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input lock_state_e          state,
  input logic [PORT_W-1:0]    owner,
  input logic                 busy,
  input logic [NUM_PORTS-1:0] rd_req,
  input logic [NUM_PORTS-1:0] rd_lock,
  input logic [NUM_PORTS-1:0] wr_req,
  input logic [NUM_PORTS-1:0] wr_lock,
  input logic [NUM_PORTS-1:0] rd_ack,
  input logic [NUM_PORTS-1:0] wr_ack,
  input logic                 dn_valid,
  input logic                 dn_lock
);

  logic [NUM_PORTS-1:0] owner_mask;
  assign owner_mask = NUM_PORTS'(1) << owner;

  p_low_port_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_IDLE && ((rd_req[0] && rd_lock[0]) || (wr_req[0] && wr_lock[0])))
    |=> (state == LS_DRAIN && owner == '0));

  p_others_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != LS_IDLE) |-> (((rd_ack | wr_ack) & ~owner_mask) == '0));

  p_drain_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_DRAIN) |-> (!dn_valid && (rd_ack | wr_ack) == '0));

  p_lock_in_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_lock |-> (state == LS_LOCKED && dn_valid));

  p_single_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (((rd_ack & rd_lock) | (wr_ack & wr_lock)) == '0));

  p_release_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_RELEASE) |=> (state == LS_IDLE));

  p_release_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_RELEASE) |-> ((rd_ack | wr_ack) == '0));

  p_one_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_ack, wr_ack}));

endmodule

bind lock_seq_arbiter lock_seq_checker #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W)
) u_lock_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (seq_state),
  .owner    (owner_q),
  .busy     (seq_busy),
  .rd_req   (rd_req),
  .rd_lock  (rd_lock),
  .wr_req   (wr_req),
  .wr_lock  (wr_lock),
  .rd_ack   (rd_ack),
  .wr_ack   (wr_ack),
  .dn_valid (dn_valid),
  .dn_lock  (dn_lock)
);

// File: tb/test_lock_seq_arbiter.sv
module test_lock_seq_arbiter;

  localparam int NP   = 3;
  localparam int NB   = 2;
  localparam int PW   = 2;
  localparam int HALF = 10;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] rd_req, rd_lock, rd_cache, wr_req, wr_lock, wr_cache;
  logic [NP-1:0] rd_ack, wr_ack, txn_done;
  logic          lookup_hit;
  logic [NB-1:0] buf_empty;
  logic          dn_valid, dn_ready, dn_write, dn_lock;
  logic [PW-1:0] dn_port;
  logic          err_outstanding, err_mix, err_dual;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_q[$];

  lock_seq_arbiter #(.NUM_PORTS(NP), .NUM_BUFS(NB)) i_lock_seq_arbiter (
    .clk, .rst_n, .rd_req, .rd_lock, .rd_cache, .wr_req, .wr_lock, .wr_cache,
    .rd_ack, .wr_ack, .txn_done, .lookup_hit, .buf_empty,
    .dn_valid, .dn_ready, .dn_write, .dn_lock, .dn_port,
    .err_outstanding, .err_mix, .err_dual
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic smp();
    #(HALF / 2);
  endtask

  task automatic clear_in();
    rd_req = '0; rd_lock = '0; rd_cache = '0;
    wr_req = '0; wr_lock = '0; wr_cache = '0;
    txn_done = '0; lookup_hit = 1'b0; dn_ready = 1'b1;
    buf_empty = '1;
  endtask

  task automatic push(input int port, input bit wr, input bit lk);
    exp_q.push_back({2'(port), wr, lk});
  endtask

  task automatic chk_acks(input string tag, input int rexp, input int wexp);
    chk({tag, " rd_ack"}, int'(rd_ack), rexp);
    chk({tag, " wr_ack"}, int'(wr_ack), wexp);
  endtask

  // Scoreboard monitor: every downstream handshake pops one prediction.
  always begin
    @(negedge clk);
    smp();
    if (rst_n && dn_valid && dn_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4/R5/R6/R11 unexpected downstream actual=%0h expected=none",
                 {dn_port, dn_write, dn_lock});
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        if ({dn_port, dn_write, dn_lock} !== e) begin
          fails++;
          $display("FAIL R4/R5/R6/R11 downstream item actual=%0h expected=%0h",
                   {dn_port, dn_write, dn_lock}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_in();
    rst_n = 1'b0;
    tick(); smp();
    chk("reset dn_valid", int'(dn_valid), 0);
    chk_acks("reset", 0, 0);
    chk("reset errors", int'({err_outstanding, err_mix, err_dual}), 0);
    tick(); rst_n = 1'b1;

    // Normal arbitration (R11)
    tick(); rd_req[1] = 1; wr_req[1] = 1; wr_req[2] = 1; push(1, 0, 0);
    smp(); chk_acks("R11 port1 read first", 3'b010, 0);
    tick(); rd_req[1] = 0; push(1, 1, 0);
    smp(); chk_acks("R11 port1 write", 0, 3'b010);
    tick(); wr_req[1] = 0; push(2, 1, 0);
    smp(); chk_acks("R11 port2 write", 0, 3'b100);
    tick(); wr_req[2] = 0; rd_req[0] = 1; rd_cache[0] = 1; lookup_hit = 1;
    smp(); chk_acks("R11 hit read local", 3'b001, 0);
    chk("R11 hit no downstream", int'(dn_valid), 0);
    tick(); lookup_hit = 0; dn_ready = 0;
    smp(); chk_acks("R11 waits for dn_ready", 0, 0);
    tick(); dn_ready = 1; push(0, 0, 0);
    smp(); chk_acks("R11 miss forwarded", 3'b001, 0);
    tick(); clear_in();

    // Priority, drain stall, blocking, release (R1 R2 R3 R4 R10)
    tick(); rd_req = 3'b011; rd_lock = 3'b011; wr_req[2] = 1; buf_empty = 2'b01;
    smp(); chk_acks("R1 start cycle", 0, 0);
    for (int i = 0; i < 3; i++) begin
      tick(); smp(); chk_acks("R3 buffers busy", 0, 0);
    end
    tick(); buf_empty = 2'b11;
    smp(); chk_acks("R3 empty seen", 0, 0);
    tick(); push(0, 0, 1);
    smp(); chk_acks("R1 port0 owns", 3'b001, 0);
    chk("R4 lock attribute", int'(dn_lock), 1);
    tick(); rd_req[0] = 0; txn_done[0] = 1;
    smp(); chk_acks("R2 others blocked", 0, 0);
    tick(); txn_done = '0; rd_req[0] = 1; rd_lock[0] = 0;
    smp(); chk_acks("R10 ending request", 0, 0);
    tick(); rd_req[0] = 0;
    smp(); chk_acks("R10 release cycle", 0, 0);
    tick(); smp(); chk_acks("R10 port1 starts", 0, 0);
    tick(); smp(); chk_acks("R2 port1 drain", 0, 0);
    tick(); push(1, 0, 1);
    smp(); chk_acks("R10 port1 after release", 3'b010, 0);
    tick(); rd_req[1] = 0; txn_done[1] = 1;
    tick(); txn_done = '0; rd_req[1] = 1; rd_lock[1] = 0;
    smp(); chk_acks("R10 port1 ends", 0, 0);
    tick(); rd_req[1] = 0;
    smp(); chk_acks("R2 port2 still blocked", 0, 0);
    tick(); push(2, 1, 0);
    smp(); chk_acks("R2 port2 served after", 0, 3'b100);
    tick(); clear_in();

    // Cacheable sequence and mix error (R5 R6 R8)
    tick(); rd_req[1] = 1; rd_lock[1] = 1; rd_cache[1] = 1; lookup_hit = 1;
    tick();
    tick(); smp(); chk_acks("R5 hit accepted", 3'b010, 0);
    chk("R5 hit no downstream", int'(dn_valid), 0);
    tick(); rd_req[1] = 0; txn_done[1] = 1;
    tick(); txn_done = '0; rd_req[1] = 1; lookup_hit = 0; push(1, 0, 0);
    smp(); chk_acks("R5 miss linefill", 3'b010, 0);
    chk("R5 linefill unlocked", int'(dn_lock), 0);
    tick(); rd_req[1] = 0; txn_done[1] = 1;
    tick(); txn_done = '0; wr_req[1] = 1; wr_lock[1] = 1; wr_cache[1] = 1; push(1, 1, 0);
    smp(); chk_acks("R6 cacheable write", 0, 3'b010);
    chk("R6 write unlocked", int'(dn_lock), 0);
    tick(); wr_req[1] = 0; txn_done[1] = 1;
    tick(); txn_done = '0; rd_req[1] = 1; rd_cache[1] = 0; push(1, 0, 1);
    smp(); chk("R8 flag not yet", int'(err_mix), 0);
    tick(); rd_req[1] = 0; txn_done[1] = 1;
    smp(); chk("R8 mix flagged", int'(err_mix), 1);
    tick(); txn_done = '0; rd_req[1] = 1; rd_lock[1] = 0;
    smp(); chk("R8 one cycle", int'(err_mix), 0);
    tick(); clear_in();
    tick();

    // Dual start and outstanding limit (R9 R7)
    tick(); rd_req[0] = 1; rd_lock[0] = 1; wr_req[0] = 1; wr_lock[0] = 1;
    smp(); chk("R9 not before", int'(err_dual), 0);
    tick(); smp(); chk("R9 dual flagged", int'(err_dual), 1);
    tick(); push(0, 0, 1);
    smp(); chk_acks("R9 read first", 3'b001, 0);
    tick(); rd_req[0] = 0;
    smp(); chk_acks("R7 write held", 0, 0);
    tick(); txn_done[0] = 1;
    smp(); chk("R7 outstanding flagged", int'(err_outstanding), 1);
    chk_acks("R7 still held", 0, 0);
    tick(); txn_done = '0; push(0, 1, 1);
    smp(); chk_acks("R7 write after done", 0, 3'b001);
    tick(); wr_req[0] = 0; txn_done[0] = 1;
    smp(); chk("R7 flag cleared", int'(err_outstanding), 0);
    tick(); txn_done = '0; wr_req[0] = 1; wr_lock[0] = 0;
    smp(); chk_acks("R10 end by write", 0, 0);
    tick(); clear_in();
    tick(); tick();

    chk("R11 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule